// File: doc/BRIEF.md
# Narrow-Slave Bus Width Adapter

This block joins a 32-bit memory-mapped master port to a slave port that is only 8 or 16 bits wide, with the slave width set by a parameter. The master side carries a byte address and four byte enables. It uses a wait-request handshake: the master holds its request and data stable until wait-request is low. The slave side uses the same handshake. Slave read data is valid in the cycle the slave accepts the read with wait-request low.

A mode parameter picks one of two address schemes.

- **Split mode:** one master word becomes a run of narrow slave beats. The slave is seen as one byte-contiguous memory. Read beats are assembled little-endian. Write beats are made only for lanes that carry an enabled byte.
- **Word mode:** each master access becomes exactly one slave access. The slave location is the master address divided by four. Read data sits in the low bits, and the bits above it return zero.

The adapter keeps the master stalled until the final beat of a run is accepted.

Top module: `bus_width_adapter`

## Requirements
- R1: Split mode, 8-bit slave: a master read turns into four slave reads at slave addresses 4*(m_addr>>2)+0..3, with m_addr[1:0] ignored, and takes 4 cycles when the slave never stalls.
- R2: Split mode, 16-bit slave: a master read turns into two slave reads at slave addresses 2*(m_addr>>2)+0..1 and takes 2 cycles when the slave never stalls.
- R3: Split mode read data is little-endian: the beat at the lowest slave address fills m_rdata[SLV_W-1:0], and each later beat fills the next SLV_W bits up.
- R4: Split mode addressing is contiguous: master words at byte addresses A and A+4 reach adjacent, non-overlapping slave address ranges.
- R5: Split mode writes make one slave write per lane. Lane k carries m_wdata[k*SLV_W +: SLV_W], and lanes whose master byte enables are all zero are skipped. A write with m_be=0 completes in one cycle with no slave access.
- R6: Split mode with a 16-bit slave drives s_be for each beat from the two master byte enables of that lane. Bit 0 enables the low slave byte.
- R7: m_waitreq stays high while a request is pending and is released only in the cycle the last beat is accepted. Each cycle of slave wait-request adds one cycle to the master access.
- R8: Word mode makes exactly one slave access per master access, at slave address m_addr>>2, whatever the byte enables.
- R9: Word mode read data returns the slave word in m_rdata[SLV_W-1:0] with all higher bits zero.
- R10: Word mode writes drive s_wdata from m_wdata[SLV_W-1:0] and s_be from m_be[SLV_W/8-1:0].
- R11: After reset, with no master request, s_read, s_write and m_waitreq are low and no slave access occurs. The first split access after reset begins at lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | ADDR_W | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_rdata | output | 32 | Master read data, valid when m_waitreq is low |
| m_waitreq | output | 1 | Master stall |
| s_addr | output | ADDR_W | Slave word address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_wdata | output | SLV_W | Slave write data |
| s_be | output | SLV_W/8 | Slave byte enables |
| s_rdata | input | SLV_W | Slave read data |
| s_waitreq | input | 1 | Slave stall |

## Verification
The beat counter is the key internal state.

- **Wrong beat count:** the assembled read word shows a wrong byte in the affected lane, or the master access finishes a cycle early or late. Both are seen in the same access.
- **Skipped-lane logic broken:** extra or missing slave writes appear. Read-back through the master then shows a corrupted or unchanged byte within the next access.
- **Stall handling broken:** a master access completes faster than the number of slave wait cycles allows, which shows up as a short cycle count.
- **Word mode errors:** duplicate slave accesses show up as a surplus access count. Nonzero upper read bits show up as a wrong data compare.

// File: rtl/bwa_pkg.sv
// Package: shared types for the bus width adapter.
// Assumes nothing beyond IEEE 1800-2017.
package bwa_pkg;

    // Address scheme: split into narrow beats, or one access per word
    typedef enum logic {
        ALIGN_SPLIT = 1'b0,
        ALIGN_WORD  = 1'b1
    } align_mode_e;

    localparam int MASTER_W  = 32;
    localparam int MASTER_BE = MASTER_W / 8;

endpackage

// File: rtl/bwa_lane_seq.sv
// Module: bwa_lane_seq
// Walks the lanes of one split master access in ascending order. It picks
// the lowest enabled lane at or above the beat counter, flags whether it is
// the last one, and advances on each accepted slave beat.
// Assumes the master holds its request stable while stalled.
module bwa_lane_seq #(
    parameter int NLANES = 4,
    parameter int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [NLANES-1:0] lane_en,
    input  logic              s_waitreq,
    output logic [LANE_W-1:0] lane_sel,
    output logic              lane_valid,
    output logic              lane_last,
    output logic              step,
    output logic              finish
);

    logic [LANE_W-1:0] beat_q;
    logic              more;

    // Select the lowest enabled lane not yet served
    always_comb begin
        lane_sel   = '0;
        lane_valid = 1'b0;
        for (int i = NLANES - 1; i >= 0; i--) begin
            if (lane_en[i] && (LANE_W'(i) >= beat_q)) begin
                lane_sel   = LANE_W'(i);
                lane_valid = 1'b1;
            end
        end
    end

    // Detect whether any enabled lane remains above the selected one
    always_comb begin
        more = 1'b0;
        for (int i = 0; i < NLANES; i++) begin
            if (lane_en[i] && (LANE_W'(i) > lane_sel)) more = 1'b1;
        end
    end

    assign lane_last = ~more;
    assign step      = req & lane_valid & ~s_waitreq;
    assign finish    = req & (~lane_valid | (step & lane_last));

    // Beat counter: restart after a finished access, else move past the served lane
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (finish) beat_q <= '0;
        else if (step)   beat_q <= lane_sel + 1'b1;
    end

    // R7: a beat is never taken while the slave stalls
    assert_no_step_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_waitreq |-> !step);

    // R11: with no request pending the counter rests at lane 0
    assert_rest_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !$past(req)) |-> (beat_q == '0));

endmodule

// File: rtl/bwa_read_asm.sv
// Module: bwa_read_asm
// Collects narrow read beats into a 32-bit word, little-endian. Earlier
// beats are held in lane registers; the final beat is passed straight
// through so the word is ready in the cycle the last beat is accepted.
// Assumes lanes are read in ascending order and the top lane is last.
module bwa_read_asm #(
    parameter int NLANES = 4,
    parameter int SLV_W  = 8,
    parameter int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [LANE_W-1:0]       lane_sel,
    input  logic [SLV_W-1:0]        s_rdata,
    output logic [NLANES*SLV_W-1:0] word
);

    logic [NLANES-1:0][SLV_W-1:0] lane_q;

    // Hold each non-final beat in its lane register
    always_ff @(posedge clk) begin
        if (!rst_n)       lane_q <= '0;
        else if (capture) lane_q[lane_sel] <= s_rdata;
    end

    // Build the output word, bypassing the lane now on the bus
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign word[g*SLV_W +: SLV_W] = (lane_sel == LANE_W'(g)) ? s_rdata : lane_q[g];
    end

endmodule

// File: rtl/bwa_write_steer.sv
// Module: bwa_write_steer
// Routes the selected lane of master write data and byte enables onto the
// narrow slave bus and reports which lanes carry any enabled byte.
// Assumes SLV_W is 8 or 16.
module bwa_write_steer #(
    parameter int NLANES = 4,
    parameter int SLV_W  = 8,
    parameter int SLV_BE = SLV_W / 8,
    parameter int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic [NLANES*SLV_W-1:0]  m_wdata,
    input  logic [NLANES*SLV_BE-1:0] m_be,
    input  logic [LANE_W-1:0]        lane_sel,
    output logic [SLV_W-1:0]         s_wdata,
    output logic [SLV_BE-1:0]        s_be,
    output logic [NLANES-1:0]        lane_en
);

    // Pick data and enables of the current lane
    assign s_wdata = m_wdata[lane_sel*SLV_W +: SLV_W];
    assign s_be    = m_be[lane_sel*SLV_BE +: SLV_BE];

    // A lane is live when any of its master byte enables is set
    for (genvar g = 0; g < NLANES; g++) begin : g_en
        assign lane_en[g] = |m_be[g*SLV_BE +: SLV_BE];
    end

endmodule

// File: rtl/bus_width_adapter.sv
// Module: bus_width_adapter (top)
// Joins a 32-bit master to an 8- or 16-bit slave. MODE selects split
// addressing (byte-contiguous, several beats per word) or word addressing
// (one access per word, slave address = master address / 4).
// Assumes m_read and m_write are never high together, the master holds its
// request stable while m_waitreq is high, and slave read data is valid when
// the slave accepts a read.
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int          SLV_W  = 8,
    parameter align_mode_e MODE   = ALIGN_SPLIT,
    parameter int          ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     m_addr,
    input  logic                  m_read,
    input  logic                  m_write,
    input  logic [MASTER_W-1:0]   m_wdata,
    input  logic [MASTER_BE-1:0]  m_be,
    output logic [MASTER_W-1:0]   m_rdata,
    output logic                  m_waitreq,
    output logic [ADDR_W-1:0]     s_addr,
    output logic                  s_read,
    output logic                  s_write,
    output logic [SLV_W-1:0]      s_wdata,
    output logic [SLV_W/8-1:0]    s_be,
    input  logic [SLV_W-1:0]      s_rdata,
    input  logic                  s_waitreq
);

    localparam int SLV_BE = SLV_W / 8;
    localparam int NLANES = MASTER_W / SLV_W;
    localparam int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1;

    logic req;
    logic unused_addr_lsb;

    assign req             = m_read | m_write;
    assign unused_addr_lsb = ^m_addr[1:0];

    if (MODE == ALIGN_SPLIT) begin : g_split
        logic [LANE_W-1:0] lane_sel;
        logic [NLANES-1:0] wr_en;
        logic [NLANES-1:0] lane_en;
        logic              lane_valid, lane_last, step, finish;

        // Reads visit every lane; writes only lanes with enabled bytes
        assign lane_en = m_write ? wr_en : {NLANES{1'b1}};

        bwa_lane_seq #(.NLANES(NLANES), .LANE_W(LANE_W)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req),
            .lane_en    (lane_en),
            .s_waitreq  (s_waitreq),
            .lane_sel   (lane_sel),
            .lane_valid (lane_valid),
            .lane_last  (lane_last),
            .step       (step),
            .finish     (finish)
        );

        bwa_write_steer #(.NLANES(NLANES), .SLV_W(SLV_W), .SLV_BE(SLV_BE), .LANE_W(LANE_W)) u_steer (
            .m_wdata  (m_wdata),
            .m_be     (m_be),
            .lane_sel (lane_sel),
            .s_wdata  (s_wdata),
            .s_be     (s_be),
            .lane_en  (wr_en)
        );

        bwa_read_asm #(.NLANES(NLANES), .SLV_W(SLV_W), .LANE_W(LANE_W)) u_asm (
            .clk      (clk),
            .rst_n    (rst_n),
            .capture  (step & ~lane_last & m_read),
            .lane_sel (lane_sel),
            .s_rdata  (s_rdata),
            .word     (m_rdata)
        );

        // Slave strobes and byte-contiguous address
        assign s_read    = m_read  & lane_valid;
        assign s_write   = m_write & lane_valid;
        assign s_addr    = ADDR_W'({m_addr[ADDR_W-1:2], lane_sel});
        assign m_waitreq = req & ~finish;

        // R3: a read completes only on the top lane
        assert_read_ends_top_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (m_read && !m_waitreq) |-> (lane_sel == LANE_W'(NLANES - 1)));

        // R5: no slave write goes out with every byte disabled
        assert_no_empty_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            s_write |-> (|s_be));

        // R1: consecutive read beats move to a higher slave address
        assert_beats_ascend_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (s_read && !s_waitreq && m_waitreq) |=> (!s_read || (s_addr > $past(s_addr))));
    end else begin : g_word
        logic unused_word;

        // One slave access per master access at the word index
        assign s_read    = m_read;
        assign s_write   = m_write;
        assign s_addr    = ADDR_W'(m_addr[ADDR_W-1:2]);
        assign s_wdata   = m_wdata[SLV_W-1:0];
        assign s_be      = m_be[SLV_BE-1:0];
        assign m_rdata   = {{(MASTER_W - SLV_W){1'b0}}, s_rdata};
        assign m_waitreq = req & s_waitreq;
        assign unused_word = ^{m_wdata, m_be};

        // R8: master completion coincides with a single accepted slave access
        assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (req && !m_waitreq) |-> ((s_read || s_write) && !s_waitreq));
    end

    // R11: no strobes without a master request
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!s_read && !s_write && !m_waitreq));

    // R7: a stalled slave beat always stalls the master
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_waitreq) |-> m_waitreq);

endmodule

// File: tb/sim_bus_width_adapter.sv
// Slave model: 64-entry memory, combinational read, programmable wait states,
// counters of accepted reads and writes.
module sim_slave #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   s_addr,
    input  logic          s_read,
    input  logic          s_write,
    input  logic [W-1:0]  s_wdata,
    input  logic [W/8-1:0] s_be,
    output logic [W-1:0]  s_rdata,
    output logic          s_waitreq,
    input  logic [3:0]    wait_cfg,
    output int            rd_cnt,
    output int            wr_cnt
);
    logic [W-1:0] mem [64];
    logic [3:0]   wcnt;

    function automatic logic [15:0] pat(input int i);
        return 16'(((i * 291) + 14940) ^ (i << 9));
    endfunction

    assign s_rdata   = mem[s_addr[5:0]];
    assign s_waitreq = (s_read | s_write) && (wcnt < wait_cfg);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt   <= '0;
            rd_cnt <= 0;
            wr_cnt <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= W'(pat(i));
        end else if (s_read | s_write) begin
            if (s_waitreq) wcnt <= wcnt + 1'b1;
            else begin
                wcnt <= '0;
                if (s_read) rd_cnt <= rd_cnt + 1;
                if (s_write) begin
                    wr_cnt <= wr_cnt + 1;
                    for (int b = 0; b < W / 8; b++)
                        if (s_be[b]) mem[s_addr[5:0]][b*8 +: 8] <= s_wdata[b*8 +: 8];
                end
            end
        end
    end
endmodule

// Bench: three adapters (split 8-bit, split 16-bit, word 16-bit), directed tests.
module sim_bus_width_adapter;
    import bwa_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] m_addr  [3];
    logic        m_rd    [3];
    logic        m_wr    [3];
    logic [31:0] m_wdata [3];
    logic [3:0]  m_be    [3];
    logic [31:0] m_rdata [3];
    logic        m_wait  [3];
    logic [3:0]  wcfg    [3];
    int          rdc     [3];
    int          wrc     [3];

    int checks = 0;
    int fails  = 0;
    int cyc;
    logic [31:0] rd_val;

    for (genvar g = 0; g < 3; g++) begin : g_dut
        localparam int W = (g == 0) ? 8 : 16;
        localparam align_mode_e M = (g == 2) ? ALIGN_WORD : ALIGN_SPLIT;
        logic [15:0]    s_ad;
        logic           s_r, s_w, s_wq;
        logic [W-1:0]   s_wd, s_rd;
        logic [W/8-1:0] s_b;

        bus_width_adapter #(.SLV_W(W), .MODE(M), .ADDR_W(16)) u0 (
            .clk(clk), .rst_n(rst_n),
            .m_addr(m_addr[g]), .m_read(m_rd[g]), .m_write(m_wr[g]),
            .m_wdata(m_wdata[g]), .m_be(m_be[g]),
            .m_rdata(m_rdata[g]), .m_waitreq(m_wait[g]),
            .s_addr(s_ad), .s_read(s_r), .s_write(s_w),
            .s_wdata(s_wd), .s_be(s_b), .s_rdata(s_rd), .s_waitreq(s_wq)
        );

        sim_slave #(.W(W)) u_slv (
            .clk(clk), .rst_n(rst_n),
            .s_addr(s_ad), .s_read(s_r), .s_write(s_w),
            .s_wdata(s_wd), .s_be(s_b), .s_rdata(s_rd), .s_waitreq(s_wq),
            .wait_cfg(wcfg[g]), .rd_cnt(rdc[g]), .wr_cnt(wrc[g])
        );
    end

    function automatic logic [15:0] pat(input int i);
        return 16'(((i * 291) + 14940) ^ (i << 9));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One master access on adapter k; returns data and cycle count
    task automatic xfer(input int k, input logic wr, input logic [15:0] a,
                        input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        m_addr[k] = a; m_wdata[k] = d; m_be[k] = be;
        m_rd[k] = ~wr; m_wr[k] = wr;
        #1;
        cyc = 1;
        while (m_wait[k]) begin
            @(negedge clk); #1;
            cyc++;
        end
        rd_val = m_rdata[k];
        @(negedge clk);
        m_rd[k] = 1'b0; m_wr[k] = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            chk("R11 idle m_waitreq", {31'd0, m_wait[k]}, 32'd0);
            chk("R11 no access after reset", rdc[k] + wrc[k], 32'd0);
        end
    endtask

    task automatic t_split8_read();
        int r0;
        r0 = rdc[0];
        xfer(0, 1'b0, 16'h0010, 32'd0, 4'hF);
        chk("R1 beat count", rdc[0] - r0, 32'd4);
        chk("R1 cycles", cyc, 32'd4);
        chk("R3 little-endian word", rd_val,
            {pat(19)[7:0], pat(18)[7:0], pat(17)[7:0], pat(16)[7:0]});
        xfer(0, 1'b0, 16'h0014, 32'd0, 4'hF);
        chk("R4 next word contiguous", rd_val,
            {pat(23)[7:0], pat(22)[7:0], pat(21)[7:0], pat(20)[7:0]});
        xfer(0, 1'b0, 16'h0013, 32'd0, 4'hF);
        chk("R1 low address bits ignored", rd_val,
            {pat(19)[7:0], pat(18)[7:0], pat(17)[7:0], pat(16)[7:0]});
    endtask

    task automatic t_split16_read();
        int r0;
        r0 = rdc[1];
        xfer(1, 1'b0, 16'h0008, 32'd0, 4'hF);
        chk("R2 beat count", rdc[1] - r0, 32'd2);
        chk("R2 cycles", cyc, 32'd2);
        chk("R3 16-bit assembly", rd_val, {pat(5), pat(4)});
    endtask

    task automatic t_stall();
        wcfg[0] = 4'd2;
        xfer(0, 1'b0, 16'h0020, 32'd0, 4'hF);
        chk("R7 stalled cycles", cyc, 32'd12);
        chk("R7 stalled data", rd_val,
            {pat(35)[7:0], pat(34)[7:0], pat(33)[7:0], pat(32)[7:0]});
        wcfg[0] = 4'd0;
    endtask

    task automatic t_split8_write();
        int w0;
        w0 = wrc[0];
        xfer(0, 1'b1, 16'h0030, 32'hAABBCCDD, 4'b1010);
        chk("R5 writes per live lane", wrc[0] - w0, 32'd2);
        chk("R5 write cycles", cyc, 32'd2);
        xfer(0, 1'b0, 16'h0030, 32'd0, 4'hF);
        chk("R5 skipped lanes untouched", rd_val,
            {8'hAA, pat(50)[7:0], 8'hCC, pat(48)[7:0]});
        w0 = wrc[0];
        xfer(0, 1'b1, 16'h0030, 32'h01020304, 4'b0000);
        chk("R5 empty write no access", wrc[0] - w0, 32'd0);
        chk("R5 empty write one cycle", cyc, 32'd1);
        xfer(0, 1'b0, 16'h0030, 32'd0, 4'hF);
        chk("R5 empty write left data", rd_val,
            {8'hAA, pat(50)[7:0], 8'hCC, pat(48)[7:0]});
    endtask

    task automatic t_split16_write();
        int w0;
        w0 = wrc[1];
        xfer(1, 1'b1, 16'h0010, 32'h11223344, 4'b0110);
        chk("R6 two partial writes", wrc[1] - w0, 32'd2);
        xfer(1, 1'b0, 16'h0010, 32'd0, 4'hF);
        chk("R6 per-byte enables", rd_val,
            {pat(9)[15:8], 8'h22, 8'h33, pat(8)[7:0]});
    endtask

    task automatic t_word();
        int r0, w0;
        r0 = rdc[2];
        xfer(2, 1'b0, 16'h000C, 32'd0, 4'hF);
        chk("R8 single read access", rdc[2] - r0, 32'd1);
        chk("R8 one cycle", cyc, 32'd1);
        chk("R9 low data, upper zero", rd_val, {16'h0000, pat(3)});
        w0 = wrc[2];
        xfer(2, 1'b1, 16'h0014, 32'hDEADBEEF, 4'b0011);
        chk("R8 single write access", wrc[2] - w0, 32'd1);
        xfer(2, 1'b0, 16'h0014, 32'd0, 4'hF);
        chk("R10 low data written", rd_val, 32'h0000BEEF);
        xfer(2, 1'b1, 16'h0018, 32'h000012AB, 4'b0001);
        xfer(2, 1'b0, 16'h0018, 32'd0, 4'hF);
        chk("R10 low byte enable only", rd_val, {16'h0000, pat(6)[15:8], 8'hAB});
        wcfg[2] = 4'd1;
        r0 = rdc[2];
        xfer(2, 1'b0, 16'h0004, 32'd0, 4'hF);
        chk("R7 word stall cycles", cyc, 32'd2);
        chk("R8 one access under stall", rdc[2] - r0, 32'd1);
        wcfg[2] = 4'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R7 watchdog expired: actual hang expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            m_addr[k] = '0; m_rd[k] = 1'b0; m_wr[k] = 1'b0;
            m_wdata[k] = '0; m_be[k] = '0; wcfg[k] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split8_read();
        t_split16_read();
        t_stall();
        t_split8_write();
        t_split16_write();
        t_word();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule